// File: doc/BRIEF.md
# Lost-Carrier-Extension Frame Statistics Register

This block keeps a saturating count of received frames that arrived with their carrier extension lost. The receive path drives a one-cycle strobe for each such frame, and the counter advances by one for every strobe. The count is made visible as the low field of a 32-bit register on a simple read/write bus port. That port has an address, a read strobe, a write strobe and write data, and it returns registered read data.

The count does not wrap. Once it reaches its all-ones value it stays there until software clears it. A mode input, driven by a control register outside this block, selects how software clears the count at run time. With the mode at 1, a read returns the count and then clears it. With the mode at 0, software clears the count by writing a fixed key value, and any other write has no effect.

Top module: `lostext_stat_reg`

## Requirements
- R1: The register reads as the count in bits 15:0 and zero in bits 31:16. Writes cannot make bits 31:16 read anything but zero.
- R2: Each clock cycle with `lost_ext_evt` high raises the count by exactly one, unless the count is saturated or a clear takes place in that cycle.
- R3: At 0xFFFF the count stops advancing and holds 0xFFFF through further events until it is cleared.
- R4: When `clr_on_rd_mode` is 1, a read strobe at the register address returns the count from before the access and sets the count to zero.
- R5: When `clr_on_rd_mode` is 0, a write strobe at the register address with write data 0x11111111 sets the count to zero.
- R6: When `clr_on_rd_mode` is 0, reads and writes of any value other than 0x11111111 leave the count unchanged. When `clr_on_rd_mode` is 1, writes leave the count unchanged.
- R7: If an event arrives in the same cycle as a clear, the count becomes 1 after that cycle.
- R8: `bus_rdata` is registered. It shows the register value in the cycle after a read strobe whose `bus_addr` equals the register address (default 0x4C), and it is zero in every other cycle, including after reads of other addresses.
- R9: While `rst_n` is low at a clock edge, the count and `bus_rdata` become zero. The reset is synchronous and active low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lost_ext_evt | input | 1 | One-cycle strobe per frame received with a lost carrier extension |
| clr_on_rd_mode | input | 1 | 1: a read clears the count; 0: writing the key clears the count |
| bus_addr | input | 8 | Register address of the bus access |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |

## Verification
The bench builds the block with its default parameters: a 16-bit count, a 32-bit bus, an 8-bit address with the register at 0x4C, and the key 0x11111111. With the full 16-bit width, a burst of a little over 65,535 events drives the count into saturation well within the run. This means the hold at 0xFFFF, and the clears that follow from that value, are exercised at the real boundary and not at a reduced width. Random traffic then mixes both clear modes, writes of the key and of other values, reads of other addresses, and events that coincide with clears.

// File: rtl/lostext_stat_pkg.sv
// Package: shared constants and the decoded-access type for the
// lost-carrier-extension statistics register.
// Assumes a single 32-bit register per instance.
package lostext_stat_pkg;

    // Bus data width of the register port.
    localparam int unsigned BUS_W = 32;

    // Key value that clears the count in write-clear mode.
    localparam logic [BUS_W-1:0] CLR_KEY = 32'h1111_1111;

    // Decoded access for the current cycle.
    typedef struct packed {
        logic hit_rd;    // read strobe at this register
        logic hit_wr;    // write strobe at this register
        logic clear;     // count must be cleared this cycle
    } stat_access_t;

endpackage

// File: rtl/lostext_access_dec.sv
// Module: lostext_access_dec
// Decodes bus strobes against the register address and works out
// whether the count is cleared in this cycle. In clear-on-read mode
// a read hit clears the count. In key mode only a write hit that
// carries the key clears it.
// Assumes read and write strobes are single-cycle and level-qualified.
module lostext_access_dec
    import lostext_stat_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h4C,
    parameter int unsigned DATA_W   = BUS_W,
    parameter logic [DATA_W-1:0] KEY = CLR_KEY
) (
    input  logic              mode_rd_clr,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output stat_access_t      acc
);

    logic addr_hit;
    logic key_seen;

    // Purpose: compare the address and the write data against constants.
    always_comb begin
        addr_hit = (addr == REG_ADDR);
        key_seen = (wdata == KEY);
    end

    // Purpose: form the hit strobes and choose the clear source by mode.
    always_comb begin
        acc.hit_rd = rd && addr_hit;
        acc.hit_wr = wr && addr_hit;
        if (mode_rd_clr) begin
            acc.clear = acc.hit_rd;
        end else begin
            acc.clear = acc.hit_wr && key_seen;
        end
    end

endmodule

// File: rtl/lostext_sat_cnt.sv
// Module: lostext_sat_cnt
// Saturating up-counter with a synchronous clear. A clear wins over
// the hold, but an event in the clear cycle is kept, so the count
// restarts at one.
// Assumes inc is a one-cycle strobe per counted frame.
module lostext_sat_cnt #(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             clr,
    output logic [WIDTH-1:0] count,
    output logic             at_max
);

    localparam logic [WIDTH-1:0] MAX_VAL = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] ONE_VAL = {{(WIDTH-1){1'b0}}, 1'b1};

    logic [WIDTH-1:0] cnt_q;
    logic [WIDTH-1:0] cnt_d;

    // Purpose: flag the saturation point.
    always_comb begin
        at_max = (cnt_q == MAX_VAL);
    end

    // Purpose: select the next count: clear, increment or hold.
    always_comb begin
        if (clr) begin
            cnt_d = inc ? ONE_VAL : '0;
        end else if (inc && !at_max) begin
            cnt_d = cnt_q + ONE_VAL;
        end else begin
            cnt_d = cnt_q;
        end
    end

    // Purpose: count register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count = cnt_q;

endmodule

// File: rtl/lostext_rd_port.sv
// Module: lostext_rd_port
// Registered read-back. It zero-extends the count into the bus word
// in the cycle after a read hit, and returns zero otherwise. It
// samples the count as it stands before any clear of the same cycle.
// Assumes CNT_W <= DATA_W.
module lostext_rd_port #(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit_rd,
    input  logic [CNT_W-1:0]  count,
    output logic [DATA_W-1:0] rdata
);

    localparam int unsigned PAD_W = DATA_W - CNT_W;

    logic [DATA_W-1:0] word;

    // Purpose: place the count in the low field; upper bits read zero.
    generate
        if (PAD_W > 0) begin : g_pad
            always_comb word = {{PAD_W{1'b0}}, count};
        end else begin : g_nopad
            always_comb word = count;
        end
    endgenerate

    // Purpose: register read data for one cycle after a read hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (hit_rd) begin
            rdata <= word;
        end else begin
            rdata <= '0;
        end
    end

endmodule

// File: rtl/lostext_stat_reg.sv
// Module: lostext_stat_reg (top)
// Statistics register that counts frames received with a lost
// carrier extension. It saturates at all-ones. The clear method is
// selected at run time: clear-on-read, or writing a key value.
// Assumes the mode input comes from a control register elsewhere and
// is stable around accesses.
module lostext_stat_reg
    import lostext_stat_pkg::*;
#(
    parameter int unsigned CNT_W    = 16,
    parameter int unsigned ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h4C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lost_ext_evt,
    input  logic              clr_on_rd_mode,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata
);

    stat_access_t     acc;
    logic [CNT_W-1:0] cnt_q;
    logic             cnt_sat;

    lostext_access_dec #(
        .ADDR_W   (ADDR_W),
        .REG_ADDR (REG_ADDR),
        .DATA_W   (BUS_W),
        .KEY      (CLR_KEY)
    ) dec_i (
        .mode_rd_clr (clr_on_rd_mode),
        .addr        (bus_addr),
        .rd          (bus_rd),
        .wr          (bus_wr),
        .wdata       (bus_wdata),
        .acc         (acc)
    );

    lostext_sat_cnt #(
        .WIDTH (CNT_W)
    ) cnt_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc    (lost_ext_evt),
        .clr    (acc.clear),
        .count  (cnt_q),
        .at_max (cnt_sat)
    );

    lostext_rd_port #(
        .CNT_W  (CNT_W),
        .DATA_W (BUS_W)
    ) rd_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .hit_rd (acc.hit_rd),
        .count  (cnt_q),
        .rdata  (bus_rdata)
    );

endmodule

// File: rtl/lostext_stat_chk.sv
// Module: lostext_stat_chk
// Assertion checker bound to lostext_stat_reg. It derives the clear
// condition from the ports on its own and compares it against the
// count held inside the block.
module lostext_stat_chk #(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned ADDR_W = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h4C
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lost_ext_evt,
    input logic              clr_on_rd_mode,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic [CNT_W-1:0]  cnt
);

    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    logic rd_hit;
    logic clr_now;

    // Purpose: recompute the clear condition from the bus ports.
    always_comb begin
        rd_hit  = bus_rd && (bus_addr == REG_ADDR);
        clr_now = clr_on_rd_mode ? rd_hit
                : (bus_wr && (bus_addr == REG_ADDR) && (bus_wdata == 32'h1111_1111));
    end

    assert_upper_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[31:CNT_W] == '0);

    assert_step_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (lost_ext_evt && !clr_now && cnt != TOP) |=> (cnt == $past(cnt) + 1'b1));

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == TOP && !clr_now) |=> (cnt == TOP));

    assert_clear_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_now && !lost_ext_evt) |=> (cnt == '0));

    assert_quiet_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_now && !lost_ext_evt) |=> $stable(cnt));

    assert_evt_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_now && lost_ext_evt) |=> (cnt == 1));

    assert_rd_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit |=> (bus_rdata[CNT_W-1:0] == $past(cnt)));

    assert_rd_idle_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_hit |=> (bus_rdata == '0));

endmodule

bind lostext_stat_reg lostext_stat_chk #(
    .CNT_W    (CNT_W),
    .ADDR_W   (ADDR_W),
    .REG_ADDR (REG_ADDR)
) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .lost_ext_evt   (lost_ext_evt),
    .clr_on_rd_mode (clr_on_rd_mode),
    .bus_addr       (bus_addr),
    .bus_rd         (bus_rd),
    .bus_wr         (bus_wr),
    .bus_wdata      (bus_wdata),
    .bus_rdata      (bus_rdata),
    .cnt            (cnt_q)
);

// File: tb/lostext_stat_reg_tb.sv
// Bench: directed corner cases, then seeded random traffic, checked
// against a behavioural model kept in bench functions.
module lostext_stat_reg_tb_top;

    localparam logic [7:0]  RADDR = 8'h4C;
    localparam logic [31:0] KEY   = 32'h1111_1111;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt = 1'b0;
    logic        mode = 1'b0;
    logic [7:0]  addr = '0;
    logic        rd = 1'b0;
    logic        wr = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;

    int          n_checks = 0;
    int          n_fail = 0;
    logic [15:0] model = '0;
    logic [31:0] exp_rd = '0;
    string       exp_tag = "R9";
    bit          done = 1'b0;

    always #5 clk = ~clk;

    lostext_stat_reg dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .lost_ext_evt   (evt),
        .clr_on_rd_mode (mode),
        .bus_addr       (addr),
        .bus_rd         (rd),
        .bus_wr         (wr),
        .bus_wdata      (wdata),
        .bus_rdata      (rdata)
    );

    // Model: is this access a clear?
    function automatic bit f_clear(bit m, bit r, bit w, logic [7:0] a, logic [31:0] d);
        if (a != RADDR) return 1'b0;
        return m ? r : (w && d == KEY);
    endfunction

    // Model: next count.
    function automatic logic [15:0] f_next(logic [15:0] c, bit e, bit clr);
        if (clr) return e ? 16'd1 : 16'd0;
        if (e && c != 16'hFFFF) return c + 16'd1;
        return c;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One cycle: check the previous cycle's read data, drive, update the model.
    task automatic step(bit e, bit m, bit r, bit w, logic [7:0] a, logic [31:0] d, string tag);
        @(negedge clk);
        check(exp_tag, rdata, exp_rd);
        evt = e; mode = m; rd = r; wr = w; addr = a; wdata = d;
        exp_rd  = (r && a == RADDR) ? {16'h0, model} : 32'h0;
        exp_tag = tag;
        model   = f_next(model, e, f_clear(m, r, w, a, d));
    endtask

    task automatic idle(string tag);
        step(1'b0, mode, 1'b0, 1'b0, 8'h00, 32'h0, tag);
    endtask

    task automatic rd_reg(bit m, string tag);
        step(1'b0, m, 1'b1, 1'b0, RADDR, 32'h0, tag);
    endtask

    initial begin
        // R9: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R9", rdata, 32'h0);
        rst_n = 1'b1;
        rd_reg(1'b0, "R9");
        idle("R9");

        // R2: five events counted
        repeat (5) step(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 32'h0, "R2");
        rd_reg(1'b0, "R2");
        // R6: a read in key mode does not clear
        rd_reg(1'b0, "R6");
        // R6: a non-key write in key mode does not clear; R1 upper bits stay zero
        step(1'b0, 1'b0, 1'b0, 1'b1, RADDR, 32'hFFFF_0003, "R6");
        rd_reg(1'b0, "R1");
        // R6: a key write in clear-on-read mode has no effect
        step(1'b0, 1'b1, 1'b0, 1'b1, RADDR, KEY, "R6");
        rd_reg(1'b0, "R6");
        // R4: clear-on-read returns the old value, then zero
        rd_reg(1'b1, "R4");
        rd_reg(1'b1, "R4");
        // R7: a key write with a coincident event leaves a count of one
        repeat (3) step(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 32'h0, "R2");
        step(1'b1, 1'b0, 1'b0, 1'b1, RADDR, KEY, "R7");
        rd_reg(1'b0, "R7");
        // R7: clear-on-read with a coincident event
        step(1'b1, 1'b1, 1'b1, 1'b0, RADDR, 32'h0, "R7");
        rd_reg(1'b0, "R7");
        // R8: a read of another address returns zero
        step(1'b0, 1'b0, 1'b1, 1'b0, 8'h48, 32'h0, "R8");
        idle("R8");
        // R5: a key write clears
        step(1'b0, 1'b0, 1'b0, 1'b1, RADDR, KEY, "R5");
        rd_reg(1'b0, "R5");
        // R3: saturation at 0xFFFF
        for (int i = 0; i < 65540; i++) step(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 32'h0, "R3");
        rd_reg(1'b0, "R3");
        step(1'b1, 1'b0, 1'b1, 1'b0, RADDR, 32'h0, "R3");
        rd_reg(1'b0, "R1");
        // R4: clear from saturation
        rd_reg(1'b1, "R4");
        rd_reg(1'b0, "R4");
        // R9: reset mid-run
        repeat (4) step(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 32'h0, "R2");
        @(negedge clk);
        check(exp_tag, rdata, exp_rd);
        rst_n = 1'b0; evt = 1'b0; rd = 1'b0; wr = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        model = '0; exp_rd = '0; exp_tag = "R9";
        rd_reg(1'b0, "R9");

        // Random traffic with a fixed seed
        void'($urandom(32'd20231));
        for (int i = 0; i < 4000; i++) begin
            bit          e = ($urandom % 3) == 0;
            bit          m = ($urandom % 2) == 0;
            bit          r = ($urandom % 3) == 0;
            bit          w = ($urandom % 4) == 0;
            logic [7:0]  a = (($urandom % 4) != 0) ? RADDR : 8'($urandom);
            logic [31:0] d = (($urandom % 2) == 0) ? KEY : $urandom;
            string       t;
            if (f_clear(m, r, w, a, d) && e) t = "R7";
            else if (r && m && a == RADDR) t = "R4";
            else if (r && a == RADDR) t = "R8";
            else if (f_clear(m, r, w, a, d)) t = "R5";
            else if (w) t = "R6";
            else t = "R2";
            step(e, m, r, w, a, d, t);
        end
        idle("R8");
        idle("R8");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule